// File: doc/BRIEF.md
# Stereo DC-Blocking High-Pass Filter with Rate-Scaled Pole

This block removes the DC offset from an interleaved stereo stream of 24-bit signed two's-complement samples. Each channel passes through its own first-order recursive filter, y[n] = x[n] - x[n-1] + (1 - a)·y[n-1], and keeps its own state. An input strobe carries a channel tag, so left and right samples may arrive in any order and with any gaps between them.

The pole constant a is always a power of two, 2^-k. The feedback term is therefore one arithmetic right shift and one subtraction, with no multiplier. A two-bit rate mode picks k. Each doubling of the sample rate adds one to k, which keeps the corner frequency roughly the same in Hz. The recursion runs on an extended-precision accumulator. The result is rounded toward minus infinity to an integer and clamped to the 24-bit range. Each filtered sample appears one clock after the sample that produced it, together with that sample's channel tag.

Top module: `dcb_hpf`

## Requirements
- R1: The rate mode sets the shift k. Code 0 gives k = 11 (single rate), code 1 gives k = 12 (dual rate) and code 2 gives k = 13 (quad rate).
- R2: Code 3 is invalid. The filter then uses k = 11, and `mode_err` is 1 in the clock after code 3 is present. `mode_err` is 0 in the clock after any other code.
- R3: Every sample accepted with `in_valid` high produces exactly one output in the next clock, with `out_valid` high and `out_chan` equal to the accepted tag. Tag 0 is left and tag 1 is right.
- R4: Each channel's state is an accumulator A with 16 fractional bits. For each sample, A <= ((x - x_prev) * 2^16) + A - floor(A / 2^k), and the output is floor(A / 2^16), clamped per R6.
- R5: A sample with one tag changes neither the stored previous input nor the accumulator of the other channel.
- R6: An output value above 8388607 is clamped to 8388607, and one below -8388608 is clamped to -8388608. The output never wraps.
- R7: Reset is synchronous and active low. It clears both channels' state, `out_valid`, `out_data` and `mode_err`. The first sample of a channel after reset therefore outputs its input value unchanged.
- R8: For a constant input held on one channel, the output magnitude never increases from one sample to the next. After 12000 samples at k = 11 it is below 1/256 of the input value.
- R9: In a clock where `in_valid` is low, `out_valid` is low in the next clock, `out_data` keeps its value, and neither channel's state changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_mode | input | 2 | Rate code: 0 single, 1 dual, 2 quad, 3 invalid |
| in_valid | input | 1 | Input sample strobe |
| in_chan | input | 1 | Channel tag of the input sample (0 left, 1 right) |
| in_data | input | 24 | Input sample, signed two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_chan | output | 1 | Channel tag of the output sample |
| out_data | output | 24 | Filtered sample, signed, clamped |
| mode_err | output | 1 | Rate code 3 was present in the previous clock |

## Verification
The bench steps full-scale inputs from one extreme to the other, in both directions. A design that wraps instead of clamping turns these into full-scale values of the wrong sign. Long pseudo-random streams in every rate code compare each output against the exact recursion. A wrong shift amount, a lost fractional bit or a rounding toward zero shows up there within a few samples after a large step. Closely interleaved left and right samples, including long runs on one channel only, expose any leakage of state between channels. The invalid rate code is applied while the accumulator is large, so a design that fell back to any shift other than 11 would produce a different output.

// File: rtl/dcb_pkg.sv
// Package: shared types and constants for the DC-blocking high-pass filter.
// Assumes two channels and a two-bit rate code.
package dcb_pkg;
    typedef enum logic [1:0] {
        RATE_SINGLE = 2'd0,
        RATE_DUAL   = 2'd1,
        RATE_QUAD   = 2'd2,
        RATE_BAD    = 2'd3
    } rate_e;

    localparam int NUM_CH = 2;
endpackage

// File: rtl/dcb_shift_sel.sv
// Maps the rate code to the pole shift amount and flags the invalid code.
// Assumes the invalid code reuses the single-rate shift.
module dcb_shift_sel #(
    parameter int SHIFT_BASE = 11,
    parameter int SH_W       = 4
) (
    input  logic [1:0]      rate_mode,
    output logic [SH_W-1:0] shift,
    output logic            bad_code
);
    import dcb_pkg::*;

    // Purpose: decode the rate code into a shift and an invalid-code flag.
    always_comb begin
        bad_code = 1'b0;
        case (rate_e'(rate_mode))
            RATE_DUAL:   shift = SH_W'(SHIFT_BASE + 1);
            RATE_QUAD:   shift = SH_W'(SHIFT_BASE + 2);
            RATE_BAD: begin
                shift    = SH_W'(SHIFT_BASE);
                bad_code = 1'b1;
            end
            default:     shift = SH_W'(SHIFT_BASE);
        endcase
    end
endmodule

// File: rtl/dcb_lane.sv
// One channel's state: the previous input and the extended accumulator.
// Computes the next accumulator from the input and stores it when load is high.
// Assumes ACC_W leaves two integer bits of headroom above DATA_W.
module dcb_lane #(
    parameter int DATA_W = 24,
    parameter int FRAC_W = 16,
    parameter int SH_W   = 4,
    localparam int ACC_W = DATA_W + 2 + FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic signed [DATA_W-1:0] x_in,
    input  logic        [SH_W-1:0]   shift,
    output logic signed [ACC_W-1:0]  acc_next
);
    logic signed [DATA_W-1:0] x_prev;
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  diff_ext;
    logic signed [ACC_W-1:0]  leak;

    // Purpose: form the input difference and the leak term, then sum them with the state.
    always_comb begin
        diff_ext = ACC_W'(x_in) - ACC_W'(x_prev);
        diff_ext = diff_ext <<< FRAC_W;
        leak     = acc >>> shift;
        acc_next = diff_ext + acc - leak;
    end

    // Purpose: store the new state for this channel when its sample arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_prev <= '0;
            acc    <= '0;
        end else if (load) begin
            x_prev <= x_in;
            acc    <= acc_next;
        end
    end
endmodule

// File: rtl/dcb_clamp.sv
// Rounds the accumulator down to an integer and clamps it to the signed output range.
// Assumes FRAC_W fractional bits in the accumulator.
module dcb_clamp #(
    parameter int DATA_W = 24,
    parameter int FRAC_W = 16,
    localparam int ACC_W = DATA_W + 2 + FRAC_W
) (
    input  logic signed [ACC_W-1:0]  acc,
    output logic signed [DATA_W-1:0] y
);
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MINV = -ACC_W'(64'sd1 <<< (DATA_W - 1));

    logic signed [ACC_W-1:0] whole;

    // Purpose: round toward minus infinity and limit the result to the output range.
    always_comb begin
        whole = acc >>> FRAC_W;
        if (whole > MAXV)      y = MAXV[DATA_W-1:0];
        else if (whole < MINV) y = MINV[DATA_W-1:0];
        else                   y = whole[DATA_W-1:0];
    end
endmodule

// File: rtl/dcb_hpf.sv
// Top level: stereo first-order DC-blocking filter with a power-of-two pole.
// One lane per channel, a shared clamp on the selected lane, registered output.
// Assumes a one-bit channel tag and at most one sample per clock.
module dcb_hpf #(
    parameter int DATA_W     = 24,
    parameter int FRAC_W     = 16,
    parameter int SHIFT_BASE = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rate_mode,
    input  logic              in_valid,
    input  logic              in_chan,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_chan,
    output logic [DATA_W-1:0] out_data,
    output logic              mode_err
);
    import dcb_pkg::*;

    localparam int ACC_W = DATA_W + 2 + FRAC_W;
    localparam int SH_W  = $clog2(SHIFT_BASE + 3);

    logic [SH_W-1:0]         shift;
    logic                    bad_code;
    logic signed [ACC_W-1:0] lane_acc [NUM_CH];
    logic signed [DATA_W-1:0] y_clamped;

    dcb_shift_sel #(.SHIFT_BASE(SHIFT_BASE), .SH_W(SH_W)) u_sel (
        .rate_mode (rate_mode),
        .shift     (shift),
        .bad_code  (bad_code)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        dcb_lane #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .SH_W(SH_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (in_valid && (in_chan == ch[0])),
            .x_in     ($signed(in_data)),
            .shift    (shift),
            .acc_next (lane_acc[ch])
        );
    end

    dcb_clamp #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_clamp (
        .acc (lane_acc[in_chan]),
        .y   (y_clamped)
    );

    // Purpose: register the filtered sample, its tag and the invalid-code flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_chan  <= 1'b0;
            out_data  <= '0;
            mode_err  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            mode_err  <= bad_code;
            if (in_valid) begin
                out_chan <= in_chan;
                out_data <= y_clamped;
            end
        end
    end
endmodule

// File: rtl/dcb_hpf_chk.sv
// Checker: timing properties at the ports of dcb_hpf, bound to every instance.
module dcb_hpf_chk #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        rate_mode,
    input logic              in_valid,
    input logic              in_chan,
    input logic [DATA_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_chan,
    input logic              mode_err
);
    p_valid_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_tag_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_chan == $past(in_chan)));
    p_bad_code_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_mode == 2'd3) |=> mode_err);
    p_good_code_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_mode != 2'd3) |=> !mode_err);
    p_idle_no_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
endmodule

bind dcb_hpf dcb_hpf_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_mode (rate_mode),
    .in_valid  (in_valid),
    .in_chan   (in_chan),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .mode_err  (mode_err)
);

// File: tb/dcb_hpf_tb.sv
// Bench for dcb_hpf: applies sample streams and compares every output against
// the recursion of R4 evaluated in 64-bit integers.
module dcb_hpf_tb;
    localparam int FR = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rate_mode = 2'd0;
    logic        in_valid = 1'b0;
    logic        in_chan = 1'b0;
    logic [23:0] in_data = '0;
    logic        out_valid, out_chan, mode_err;
    logic [23:0] out_data;

    int n_vec = 0;
    int n_bad = 0;
    longint m_acc [2];
    longint m_xp  [2];
    longint last_y;
    logic [31:0] lcg = 32'h1234_5678;

    always #5 clk = ~clk;

    dcb_hpf u_dut (
        .clk(clk), .rst_n(rst_n), .rate_mode(rate_mode),
        .in_valid(in_valid), .in_chan(in_chan), .in_data(in_data),
        .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data),
        .mode_err(mode_err)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint sat24(input longint v);
        if (v > 64'sd8388607) return 64'sd8388607;
        if (v < -64'sd8388608) return -64'sd8388608;
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 2; c++) begin m_acc[c] = 0; m_xp[c] = 0; end
    endtask

    // Drives one sample, then checks the output one clock later (R3, R4).
    task automatic apply(input int ch, input longint x, input logic [1:0] md, input string req);
        int k;
        longint y;
        k = (md == 2'd1) ? 12 : (md == 2'd2) ? 13 : 11;
        m_acc[ch] = ((x - m_xp[ch]) <<< FR) + m_acc[ch] - (m_acc[ch] >>> k);
        m_xp[ch]  = x;
        y = sat24(m_acc[ch] >>> FR);
        in_valid = 1'b1; in_chan = ch[0]; in_data = x[23:0]; rate_mode = md;
        @(negedge clk);
        check({req, " R4 data"}, longint'($signed(out_data)), y);
        check("R3 valid", longint'(out_valid), 1);
        check("R3 tag", longint'(out_chan), longint'(ch));
        check("R2 flag", longint'(mode_err), (md == 2'd3) ? 1 : 0);
        last_y = y;
        in_valid = 1'b0;
    endtask

    function automatic longint rnd24();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return longint'($signed(lcg[31:8]));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        longint held;
        do_reset();
        // R7: reset state at the outputs
        check("R7 out_valid", longint'(out_valid), 0);
        check("R7 out_data", longint'(out_data), 0);
        check("R7 mode_err", longint'(mode_err), 0);
        // R7: first sample passes through unchanged
        apply(0, 5000, 2'd0, "R7");
        check("R7 first", last_y, 5000);
        apply(1, -777, 2'd0, "R7");
        check("R7 first right", last_y, -777);

        // R1, R4, R5: random interleaved streams in each valid rate code
        for (int md = 0; md < 3; md++) begin
            for (int i = 0; i < 400; i++) begin
                apply(((lcg[3] ^ lcg[17]) ? 1 : 0), rnd24(), 2'(md), "R1");
            end
            for (int i = 0; i < 60; i++) apply(0, 3000000, 2'(md), "R1 step");
        end

        // R5: long right-only run, then left continues from its own state
        held = 123456;
        apply(0, held, 2'd0, "R5");
        for (int i = 0; i < 300; i++) apply(1, rnd24(), 2'd0, "R5");
        apply(0, held, 2'd0, "R5 left resumes");

        // R6: full-scale steps in both directions
        do_reset();
        apply(0, -8388608, 2'd0, "R6");
        apply(0, 8388607, 2'd0, "R6");
        check("R6 clamp high", longint'($signed(out_data)), 8388607);
        apply(0, -8388608, 2'd0, "R6");
        check("R6 clamp low", longint'($signed(out_data)), -8388608);
        apply(1, 8388607, 2'd2, "R6");
        apply(1, -8388608, 2'd2, "R6");
        check("R6 clamp low right", longint'($signed(out_data)), -8388608);

        // R2: invalid code with a large accumulator uses the single-rate shift
        apply(0, 4000000, 2'd0, "R2");
        for (int i = 0; i < 20; i++) apply(0, 4000000, 2'd3, "R2");
        for (int i = 0; i < 20; i++) apply(1, -4000000, 2'd3, "R2");

        // R9: idle clocks hold the output and the state
        @(negedge clk);
        check("R9 no valid", longint'(out_valid), 0);
        check("R9 hold", longint'($signed(out_data)), last_y);
        repeat (5) @(negedge clk);
        check("R9 hold later", longint'($signed(out_data)), last_y);
        apply(1, -4000000, 2'd0, "R9 resume");

        // R8: constant input decays without growing
        do_reset();
        begin
            longint prev_mag, mag;
            prev_mag = 64'sd1 <<< 40;
            for (int i = 0; i < 12000; i++) begin
                apply(0, 1000000, 2'd0, "R8");
                mag = (last_y < 0) ? -last_y : last_y;
                if (mag > prev_mag) check("R8 monotone", mag, prev_mag);
                prev_mag = mag;
            end
            check("R8 decayed", (prev_mag < 1000000 / 256) ? 1 : 0, 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule